// File: doc/BRIEF.md
# CPU Wait-State Hold with Watchdog Release

This block stalls a host CPU after a command write to a disk controller and lets it run again as soon as the controller is ready. A write to the drive-select register with the hold bit set arms a hold latch. While the latch is set, the active-low `wait_n` line keeps the CPU in a wait state. The latch clears when the controller raises its interrupt request or its data request, or when the system is reset.

A watchdog counter bounds every hold. It counts 1 MHz timing enables that arrive as single-cycle pulses in the system clock domain. It stays at zero while no hold is pending. When it reaches 1024 enables it releases the CPU and raises a one-cycle timeout flag. This happens even if the controller never answers.

The control is a two-state machine. In S_IDLE the CPU runs and the counter is held at zero. In S_HOLD the CPU is stalled and the counter advances. The ARM transition goes from S_IDLE to S_HOLD on an arming write when no release source is active. The RELEASE transition goes from S_HOLD to S_IDLE when the interrupt request, the data request or the watchdog tap is active. The RESET transition forces S_IDLE from either state.

Top module: `wait_state_gen`

## Requirements
- R1: A cycle with `wr_stb` high and `wr_data` bit 6 set, arriving in S_IDLE with no release source active, drives `wait_n` low from the next clock edge.
- R2: A write with `wr_data` bit 6 clear does not arm the hold, and neither does bit 6 presented while `wr_stb` is low. In both cases `wait_n` stays high.
- R3: Once armed, `wait_n` stays low while no release source is active and fewer than 1024 timing enables have been counted.
- R4: `ctl_intrq` high for one cycle in S_HOLD drives `wait_n` high at the next clock edge.
- R5: `ctl_drq` high for one cycle in S_HOLD drives `wait_n` high at the next clock edge.
- R6: `rst` is synchronous and active high. It drives `wait_n` high and `timeout_pulse` low at the next clock edge, in any state.
- R7: When an arming write and an active `ctl_intrq` or `ctl_drq` fall in the same cycle, the release wins and `wait_n` stays high.
- R8: The counter counts only clock edges in S_HOLD with `tick_1us` high. After the 1024th such edge, `wait_n` goes high at the following edge. After 1023 such edges, the hold is still in place.
- R9: `timeout_pulse` is high for exactly one cycle, at the same edge where a timeout releases the hold. A release caused by a request does not raise it.
- R10: The counter is held at zero while no hold is pending. Every hold starts counting from zero, whatever enables arrived while idle or during an earlier hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also a release source |
| tick_1us | input | 1 | One-cycle timing enable at 1 MHz |
| wr_stb | input | 1 | Drive-select register write strobe |
| wr_data | input | 8 | Write data; bit 6 arms the hold |
| ctl_intrq | input | 1 | Controller interrupt request |
| ctl_drq | input | 1 | Controller data request |
| wait_n | output | 1 | Active-low wait line to the CPU |
| timeout_pulse | output | 1 | One-cycle flag on a watchdog release |

## Verification
The assertions check on every cycle that a request in S_HOLD releases the CPU at the next edge and that a release beats a simultaneous arming write. They also check that the timeout flag never lasts two cycles and coincides with a released CPU, and that the counter never passes the tap value. The exact 1024-versus-1023 count boundary and the restart of the count from zero after idle enables or an early release are visible only in the bench scenarios. So are the per-source release checks driven from the stimulus table, because they depend on the history of enables across several holds.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } hold_state_t;
endpackage

// File: rtl/wsg_release.sv
// Combines the release sources into one clear request.
module wsg_release #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] src,
    output logic             any
);
    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N_SRC; i++) begin : g_or
        assign chain[i+1] = chain[i] | src[i];
    end
    assign any = chain[N_SRC];
endmodule

// File: rtl/wsg_watchdog.sv
// Counts timing enables while a hold runs; cleared when idle or released.
module wsg_watchdog #(
    parameter int CNT_W = 12,
    parameter int TAP   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    input  logic tick,
    output logic hit
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << TAP;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign hit = cnt[TAP];

    // R8: the count never passes the tap value
    a_r8_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);
    // R10: with no hold running, the count is zero one edge later
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> (cnt == '0));
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
    parameter int DATA_W  = 8,
    parameter int ARM_BIT = 6,
    parameter int CNT_W   = 12,
    parameter int TAP     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1us,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ctl_intrq,
    input  logic              ctl_drq,
    output logic              wait_n,
    output logic              timeout_pulse
);
    import wsg_pkg::*;

    localparam int N_SRC = 3;

    hold_state_t      state, state_nxt;
    logic             arm_req;
    logic             release_any;
    logic             tmo_hit;
    logic [N_SRC-1:0] rel_src;

    assign arm_req = wr_stb && wr_data[ARM_BIT];
    assign rel_src = {tmo_hit, ctl_drq, ctl_intrq};

    wsg_release #(.N_SRC(N_SRC)) u_release (
        .src (rel_src),
        .any (release_any)
    );

    wsg_watchdog #(.CNT_W(CNT_W), .TAP(TAP)) u_watchdog (
        .clk  (clk),
        .rst  (rst),
        .run  (state == S_HOLD),
        .clr  (release_any),
        .tick (tick_1us),
        .hit  (tmo_hit)
    );

    // next-state logic: ARM, RELEASE
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (arm_req && !release_any) state_nxt = S_HOLD;
            S_HOLD: if (release_any)             state_nxt = S_IDLE;
        endcase
    end

    // state register: RESET wins
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nxt;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) timeout_pulse <= 1'b0;
        else     timeout_pulse <= (state == S_HOLD) && tmo_hit;
    end

    assign wait_n = (state != S_HOLD);

    // R4 / R5: a request during a hold frees the CPU at the next edge
    a_r4_r5_release: assert property (@(posedge clk) disable iff (rst)
        (!wait_n && (ctl_intrq || ctl_drq)) |=> wait_n);
    // R7: release beats a simultaneous arming write
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (wait_n && wr_stb && wr_data[ARM_BIT] && (ctl_intrq || ctl_drq)) |=> wait_n);
    // R1: a clean arming write from idle stalls the CPU
    a_r1_arm: assert property (@(posedge clk) disable iff (rst)
        (wait_n && wr_stb && wr_data[ARM_BIT] && !ctl_intrq && !ctl_drq) |=> !wait_n);
    // R9: the timeout flag is a single-cycle pulse
    a_r9_single: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> !timeout_pulse);
    // R9: the timeout flag comes with a released CPU that had been held
    a_r9_with_release: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> (wait_n && !$past(wait_n)));
endmodule

// File: tb/tb_wait_state_gen.sv
`timescale 1ns/1ps
module tb_wait_state_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1us = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ctl_intrq = 1'b0;
    logic       ctl_drq = 1'b0;
    logic       wait_n;
    logic       timeout_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wait_state_gen dut (
        .clk           (clk),
        .rst           (rst),
        .tick_1us      (tick_1us),
        .wr_stb        (wr_stb),
        .wr_data       (wr_data),
        .ctl_intrq     (ctl_intrq),
        .ctl_drq       (ctl_drq),
        .wait_n        (wait_n),
        .timeout_pulse (timeout_pulse)
    );

    // vector: data[11:4], source[3:2] (0 none,1 intrq,2 drq,3 rst),
    //         expect armed [1], expect wait_n after source [0]
    localparam int NV = 6;
    localparam logic [11:0] VEC [NV] = '{
        {8'h40, 2'd1, 1'b1, 1'b1},
        {8'h41, 2'd2, 1'b1, 1'b1},
        {8'hFF, 2'd3, 1'b1, 1'b1},
        {8'hBF, 2'd1, 1'b0, 1'b1},
        {8'hC0, 2'd0, 1'b1, 1'b0},
        {8'h00, 2'd2, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d);
        wr_stb = 1'b1; wr_data = d; step(); wr_stb = 1'b0; wr_data = 8'h00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1us = 1'b1; step(); tick_1us = 1'b0; step();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        step(); step();
        rst = 1'b0;
        // R6: reset state
        chk("R6 reset wait_n", wait_n, 1'b1);
        chk("R6 reset timeout", timeout_pulse, 1'b0);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            write(VEC[v][11:4]);
            chk("R1/R2 arm", wait_n, !VEC[v][1]);
            ticks(5);
            chk("R3 hold", wait_n, !VEC[v][1]);
            unique case (VEC[v][3:2])
                2'd1: begin ctl_intrq = 1'b1; step(); ctl_intrq = 1'b0; end
                2'd2: begin ctl_drq = 1'b1; step(); ctl_drq = 1'b0; end
                2'd3: begin rst = 1'b1; step(); rst = 1'b0; end
                default: step();
            endcase
            chk("R4/R5/R6 release", wait_n, VEC[v][0]);
            chk("R9 no flag on request", timeout_pulse, 1'b0);
            do_reset();
        end

        // R2: bit 6 present without strobe
        wr_data = 8'h40; step(); wr_data = 8'h00;
        chk("R2 no strobe", wait_n, 1'b1);

        // R7: release wins over same-cycle arm
        ctl_intrq = 1'b1; write(8'h40); ctl_intrq = 1'b0;
        chk("R7 intrq wins", wait_n, 1'b1);
        ctl_drq = 1'b1; write(8'h40); ctl_drq = 1'b0;
        chk("R7 drq wins", wait_n, 1'b1);

        // R10: enables while idle do not count
        ticks(1500);
        write(8'h40);
        ticks(1023);
        chk("R8 R10 1023 still held", wait_n, 1'b0);
        tick_1us = 1'b1; step(); tick_1us = 1'b0;
        chk("R8 hold at 1024th edge", wait_n, 1'b0);
        chk("R9 no flag yet", timeout_pulse, 1'b0);
        step();
        chk("R8 timeout release", wait_n, 1'b1);
        chk("R9 flag high", timeout_pulse, 1'b1);
        step();
        chk("R9 flag one cycle", timeout_pulse, 1'b0);

        // R10: early release then new hold restarts from zero
        write(8'h40);
        ticks(600);
        ctl_drq = 1'b1; step(); ctl_drq = 1'b0;
        chk("R5 early release", wait_n, 1'b1);
        write(8'h40);
        ticks(1023);
        chk("R10 restart from zero", wait_n, 1'b0);
        ticks(1);
        chk("R8 second timeout", wait_n, 1'b1);
        chk("R9 second flag", timeout_pulse, 1'b1);

        // R3: plain clocks without enables keep the hold
        write(8'h40);
        repeat (3000) step();
        chk("R3 no enables no timeout", wait_n, 1'b0);
        ctl_intrq = 1'b1; step(); ctl_intrq = 1'b0;
        chk("R4 final release", wait_n, 1'b1);

        finish_run();
    end
endmodule